// File: doc/BRIEF.md
# Indirect Interrupt-Router Register Window

This block is the register front end of an interrupt routing controller. Software reaches everything through two bus offsets. One offset holds an 8-bit select register that stores an index. The other offset is a data window: a read or write there goes to whichever internal register the current index names. Behind the window sit a 4-bit controller identifier, a read-only version word and a table of 64-bit redirection entries. Each entry is reached as two 32-bit halves, and the least significant bit of the index picks the half.

The whole table is driven out in parallel to the delivery logic. The delivery logic sets an entry's remote-pending flag through a per-pin strobe. The block reports two kinds of event as one-cycle pulses: a change of an entry's mask bit, and any accepted write to the table.

Each entry has this layout: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, remote-pending in bit 14, trigger mode in bit 15 (1 = level), mask in bit 16 and destination in bits 63:56. The default configuration has 24 pins, the select register at offset 0x00, the window at offset 0x10 and version code 0x11.

Top module: `irw_top`

## Requirements
- R1: A write at the select offset (0x00) stores data bits 7:0 as the index. A read at that offset returns the index zero-extended to 32 bits.
- R2: With index 0x01, a window read returns PINS-1 in bits 23:16 and the version code in bits 7:0, with all other bits zero (0x00170011 by default). A window write at this index changes nothing.
- R3: With index 0x00, a window write stores data bits 27:24 as the identifier. A window read at index 0x00 or at index 0x02 returns the identifier in bits 27:24 and zero elsewhere. A window write at index 0x02 changes nothing.
- R4: An index of 0x10 + 2n reaches bits 31:0 of entry n, and 0x11 + 2n reaches bits 63:32. A write to one half leaves the other half unchanged. Entry n appears on entTable bits n*64+63 down to n*64.
- R5: An index in 0x03..0x0F, or one whose entry number is PINS or more (0x40 and up by default), reads as 0xFFFFFFFF through the window. A write at such an index changes no entry and raises no tblWr pulse.
- R6: A write to the low half of an entry forces its remote-pending bit 14 to 0, whatever the written value. Otherwise a pulse on remoteSet[n] sets bit 14 of entry n. When both happen in the same cycle, the write wins.
- R7: If a low-half write gives bit 16 a value different from the value it held, maskChg pulses high for one cycle with maskPin = n and maskVal = the new bit. A write that keeps the mask raises no maskChg.
- R8: Every accepted entry write, to either half, raises tblWr for one cycle with tblPin = n.
- R9: After reset, every entry holds 0x0000_0000_0001_0000 (only the mask bit set), and the index, the identifier and busRdata are 0.
- R10: A read or write at any offset other than 0x00 and 0x10 returns 0 on a read and changes no state on a write.
- R11: Writes take effect at the clock edge that samples them. busRdata is updated at the edge that samples a read and holds its value until the next read. maskChg and tblWr are valid in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| remoteSet | input | PINS | Per-pin strobe that sets remote-pending |
| busRdata | output | 32 | Registered read data |
| entTable | output | PINS*64 | All redirection entries, entry n at bits n*64 upward |
| maskChg | output | 1 | Pulse: a write changed an entry's mask bit |
| maskPin | output | $clog2(PINS) | Pin number of the mask change |
| maskVal | output | 1 | New mask value |
| tblWr | output | 1 | Pulse: an entry half was written |
| tblPin | output | $clog2(PINS) | Pin number of the table write |

## Verification
The hardest case to reach from the ports is a remote-pending flag that is set and then written over. The flag can only be set by the delivery strobe, so the stimulus first pulses remoteSet and reads the flag back. It then writes the upper half, where the flag must survive, and after that the lower half with bit 14 set in the data, where the flag must be cleared. It also drives the strobe in the same cycle as a low-half write to confirm that the write wins. A read sweep over all 256 index values, compared against a bench model, covers the gaps below 0x10 and the indices past the last pin.

// File: rtl/irw_pkg.sv
`timescale 1ns/1ps
package irw_pkg;

  typedef enum logic [2:0] {
    RD_ZERO, RD_SEL, RD_ID, RD_VER, RD_LO, RD_HI, RD_ONES
  } rdSrc_e;

  typedef struct packed {
    logic   selWr;
    logic   idWr;
    logic   entWrLo;
    logic   entWrHi;
    logic   rdEn;
    rdSrc_e rdSrc;
    logic [7:0] pin;
  } strobe_t;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;
  localparam logic [7:0] IDX_ARB = 8'h02;
  localparam logic [7:0] IDX_TBL = 8'h10;

  localparam int BIT_REMOTE = 14;
  localparam int BIT_MASK   = 16;

endpackage

// File: rtl/irw_ctrl.sv
`timescale 1ns/1ps
module irw_ctrl
  import irw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PINS    = 24,
  parameter int SEL_OFF = 'h00,
  parameter int WIN_OFF = 'h10
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        selReg,
  output strobe_t           stb
);

  localparam logic [7:0] PINS_B = 8'(PINS);

  logic [7:0] tblOff;
  logic [7:0] entNum;
  logic       inTbl;
  logic       hitSel;
  logic       hitWin;

  always_comb begin
    tblOff = selReg - IDX_TBL;
    entNum = {1'b0, tblOff[7:1]};
    inTbl  = (selReg >= IDX_TBL) && (entNum < PINS_B);
    hitSel = busValid && (busAddr == ADDR_W'(SEL_OFF));
    hitWin = busValid && (busAddr == ADDR_W'(WIN_OFF));

    stb         = '0;
    stb.rdSrc   = RD_ZERO;
    stb.pin     = entNum;
    stb.rdEn    = busValid && !busWrite;
    stb.selWr   = hitSel && busWrite;

    if (hitWin && busWrite) begin
      stb.idWr    = (selReg == IDX_ID);
      stb.entWrLo = inTbl && !selReg[0];
      stb.entWrHi = inTbl && selReg[0];
    end

    if (hitSel) begin
      stb.rdSrc = RD_SEL;
    end else if (hitWin) begin
      if (selReg == IDX_ID || selReg == IDX_ARB) begin
        stb.rdSrc = RD_ID;
      end else if (selReg == IDX_VER) begin
        stb.rdSrc = RD_VER;
      end else if (inTbl) begin
        stb.rdSrc = selReg[0] ? RD_HI : RD_LO;
      end else begin
        stb.rdSrc = RD_ONES;
      end
    end
  end

endmodule

// File: rtl/irw_dpath.sv
`timescale 1ns/1ps
module irw_dpath
  import irw_pkg::*;
#(
  parameter int         PINS     = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int        PIN_W    = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [31:0]       wData,
  input  logic [PINS-1:0]   remoteSet,
  output logic [7:0]        selReg,
  output logic [31:0]       rdData,
  output logic [PINS*64-1:0] entTable,
  output logic              maskChg,
  output logic [PIN_W-1:0]  maskPin,
  output logic              maskVal,
  output logic              tblWr,
  output logic [PIN_W-1:0]  tblPin
);

  localparam logic [63:0] ENT_RST = 64'h1 << BIT_MASK;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

  logic [63:0]      entReg [PINS];
  logic [3:0]       idReg;
  logic [PIN_W-1:0] pinSel;
  logic [63:0]      curEnt;
  logic [31:0]      loData;
  logic [31:0]      rdNext;

  assign pinSel = stb.pin[PIN_W-1:0];
  assign curEnt = entReg[pinSel];

  always_comb begin
    loData             = wData;
    loData[BIT_REMOTE] = 1'b0;
  end

  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : gEnt
      always_ff @(posedge clk) begin
        if (!rstN) begin
          entReg[g] <= ENT_RST;
        end else begin
          if (stb.entWrLo && pinSel == PIN_W'(g)) begin
            entReg[g][31:0] <= loData;
          end else if (remoteSet[g]) begin
            entReg[g][BIT_REMOTE] <= 1'b1;
          end
          if (stb.entWrHi && pinSel == PIN_W'(g)) begin
            entReg[g][63:32] <= wData;
          end
        end
      end
      assign entTable[g*64 +: 64] = entReg[g];
    end
  endgenerate

  always_comb begin
    unique case (stb.rdSrc)
      RD_SEL:  rdNext = {24'h0, selReg};
      RD_ID:   rdNext = {4'h0, idReg, 24'h0};
      RD_VER:  rdNext = VER_WORD;
      RD_LO:   rdNext = curEnt[31:0];
      RD_HI:   rdNext = curEnt[63:32];
      RD_ONES: rdNext = '1;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg  <= '0;
      idReg   <= '0;
      rdData  <= '0;
      maskChg <= 1'b0;
      maskPin <= '0;
      maskVal <= 1'b0;
      tblWr   <= 1'b0;
      tblPin  <= '0;
    end else begin
      if (stb.selWr) selReg <= wData[7:0];
      if (stb.idWr)  idReg  <= wData[27:24];
      if (stb.rdEn)  rdData <= rdNext;
      maskChg <= stb.entWrLo && (curEnt[BIT_MASK] != wData[BIT_MASK]);
      maskPin <= pinSel;
      maskVal <= wData[BIT_MASK];
      tblWr   <= stb.entWrLo || stb.entWrHi;
      tblPin  <= pinSel;
    end
  end

endmodule

// File: rtl/irw_top.sv
`timescale 1ns/1ps
module irw_top
  import irw_pkg::*;
#(
  parameter int         PINS     = 24,
  parameter int         ADDR_W   = 8,
  parameter int         SEL_OFF  = 'h00,
  parameter int         WIN_OFF  = 'h10,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int        PIN_W    = $clog2(PINS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  input  logic [PINS-1:0]    remoteSet,
  output logic [31:0]        busRdata,
  output logic [PINS*64-1:0] entTable,
  output logic               maskChg,
  output logic [PIN_W-1:0]   maskPin,
  output logic               maskVal,
  output logic               tblWr,
  output logic [PIN_W-1:0]   tblPin
);

  strobe_t    stb;
  logic [7:0] selReg;

  irw_ctrl #(
    .ADDR_W(ADDR_W), .PINS(PINS), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF)
  ) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .selReg(selReg), .stb(stb)
  );

  irw_dpath #(.PINS(PINS), .VER_CODE(VER_CODE)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wData(busWdata),
    .remoteSet(remoteSet), .selReg(selReg), .rdData(busRdata),
    .entTable(entTable), .maskChg(maskChg), .maskPin(maskPin),
    .maskVal(maskVal), .tblWr(tblWr), .tblPin(tblPin)
  );

endmodule

// File: rtl/irw_chk.sv
`timescale 1ns/1ps
module irw_chk
  import irw_pkg::*;
#(
  parameter int PINS    = 24,
  parameter int ADDR_W  = 8,
  parameter int SEL_OFF = 'h00,
  localparam int PIN_W  = $clog2(PINS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input strobe_t            stb,
  input logic [7:0]         selReg,
  input logic [PINS-1:0]    remoteSet,
  input logic [PINS*64-1:0] entTable,
  input logic               maskChg,
  input logic               tblWr,
  input logic [PIN_W-1:0]   tblPin
);

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite && busAddr == ADDR_W'(SEL_OFF)) |=> $stable(selReg)); // R1

  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.entWrHi && stb.pin == 8'd0 && !remoteSet[0])
      |=> entTable[31:0] == $past(entTable[31:0])); // R4

  AST_OOR_PIN: assert property (@(posedge clk) disable iff (!rstN)
    tblWr |-> (32'(tblPin) < PINS)); // R5

  AST_REMOTE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (stb.entWrLo && stb.pin == 8'd0) |=> !entTable[BIT_REMOTE]); // R6

  AST_MASK_WITH_WR: assert property (@(posedge clk) disable iff (!rstN)
    maskChg |-> tblWr); // R7

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.entWrLo || stb.entWrHi) |=> !tblWr); // R8

endmodule

bind irw_top irw_chk #(.PINS(PINS), .ADDR_W(ADDR_W), .SEL_OFF(SEL_OFF)) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .stb(stb), .selReg(selReg), .remoteSet(remoteSet),
  .entTable(entTable), .maskChg(maskChg), .tblWr(tblWr), .tblPin(tblPin)
);

// File: tb/tb_irw_top.sv
`timescale 1ns/1ps
module tb_irw_top;

  localparam int PINS  = 24;
  localparam int PIN_W = $clog2(PINS);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               busValid = 1'b0;
  logic               busWrite = 1'b0;
  logic [7:0]         busAddr = '0;
  logic [31:0]        busWdata = '0;
  logic [PINS-1:0]    remoteSet = '0;
  logic [31:0]        busRdata;
  logic [PINS*64-1:0] entTable;
  logic               maskChg;
  logic [PIN_W-1:0]   maskPin;
  logic               maskVal;
  logic               tblWr;
  logic [PIN_W-1:0]   tblPin;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] model [PINS];
  logic [3:0]  mId;

  irw_top dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .remoteSet(remoteSet),
    .busRdata(busRdata), .entTable(entTable), .maskChg(maskChg),
    .maskPin(maskPin), .maskVal(maskVal), .tblWr(tblWr), .tblPin(tblPin)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = w; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic winWr(input logic [7:0] idx, input logic [31:0] d);
    access(1, 8'h00, {24'h0, idx});
    access(1, 8'h10, d);
  endtask

  task automatic winRd(input logic [7:0] idx, output logic [31:0] v);
    access(1, 8'h00, {24'h0, idx});
    access(0, 8'h10, 32'h0);
    v = busRdata;
  endtask

  function automatic logic [31:0] expRd(input int idx);
    int n;
    if (idx == 0 || idx == 2) return {4'h0, mId, 24'h0};
    if (idx == 1) return 32'h0017_0011;
    n = (idx - 16) / 2;
    if (idx >= 16 && n < PINS) return (idx % 2 == 1) ? model[n][63:32] : model[n][31:0];
    return 32'hFFFF_FFFF;
  endfunction

  task automatic tableCheck(input string req);
    for (int p = 0; p < PINS; p++) check(req, entTable[p*64 +: 64], model[p]);
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] lo, hi;
    for (int p = 0; p < PINS; p++) model[p] = 64'h1_0000;
    mId = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    check("R9 rdata", {32'h0, busRdata}, 64'h0);
    tableCheck("R9 table");
    access(0, 8'h00, 32'h0);
    check("R9 sel", {32'h0, busRdata}, 64'h0);
    winRd(8'h00, v);
    check("R9 id", {32'h0, v}, 64'h0);

    // R1: select register keeps 8 bits
    access(1, 8'h00, 32'h0000_01AB);
    access(0, 8'h00, 32'h0);
    check("R1 sel", {32'h0, busRdata}, 64'hAB);

    // R10: other offsets
    access(1, 8'h04, 32'h0000_0033);
    access(1, 8'h20, 32'hFFFF_FFFF);
    access(0, 8'h00, 32'h0);
    check("R10 sel kept", {32'h0, busRdata}, 64'hAB);
    access(0, 8'h20, 32'h0);
    check("R10 rd zero", {32'h0, busRdata}, 64'h0);
    tableCheck("R10 table");

    // R11: read data holds with no read
    @(negedge clk);
    check("R11 hold", {32'h0, busRdata}, 64'h0);

    // R3: identifier
    winWr(8'h00, 32'hF500_0000);
    mId = 4'h5;
    winRd(8'h00, v);
    check("R3 id", {32'h0, v}, {32'h0, expRd(0)});
    winWr(8'h02, 32'h0A00_0000);
    winRd(8'h02, v);
    check("R3 arb", {32'h0, v}, 64'h0500_0000);

    // R2: version
    winWr(8'h01, 32'h1234_5678);
    winRd(8'h01, v);
    check("R2 ver", {32'h0, v}, 64'h0017_0011);

    // R4 R7 R8: per-pin sweep
    for (int p = 0; p < PINS; p++) begin
      lo = 32'(p) | (32'(p % 8) << 8) | 32'h4000 | (32'(p % 2) << 15);
      hi = {8'(p + 8'h80), 24'(p * 32'h111)};
      access(1, 8'h00, 32'(16 + 2 * p));
      access(1, 8'h10, lo);
      check("R7 mask chg", {63'h0, maskChg}, 64'h1);
      check("R7 mask pin", 64'(maskPin), 64'(p));
      check("R7 mask val", {63'h0, maskVal}, 64'h0);
      check("R8 wr pulse", {63'h0, tblWr}, 64'h1);
      check("R8 wr pin", 64'(tblPin), 64'(p));
      model[p][31:0] = lo & ~32'h4000;
      winWr(8'(17 + 2 * p), hi);
      check("R8 hi pulse", {63'h0, tblWr}, 64'h1);
      check("R7 hi no chg", {63'h0, maskChg}, 64'h0);
      model[p][63:32] = hi;
      check("R4 table", entTable[p*64 +: 64], model[p]);
    end
    for (int p = 0; p < PINS; p++) begin
      winRd(8'(16 + 2 * p), v);
      check("R6 lo read", {32'h0, v}, {32'h0, model[p][31:0]});
      winRd(8'(17 + 2 * p), v);
      check("R4 hi read", {32'h0, v}, {32'h0, model[p][63:32]});
    end

    // R7: same mask, then set mask
    winWr(8'h1A, model[5][31:0]);
    check("R7 same mask", {63'h0, maskChg}, 64'h0);
    check("R8 same mask wr", {63'h0, tblWr}, 64'h1);
    winWr(8'h1A, model[5][31:0] | 32'h1_0000);
    model[5][16] = 1'b1;
    check("R7 set mask", {63'h0, maskChg}, 64'h1);
    check("R7 set val", {63'h0, maskVal}, 64'h1);
    check("R7 set pin", 64'(maskPin), 64'd5);

    // R6: remote-pending flag
    remoteSet[7] = 1'b1;
    @(posedge clk); #1; remoteSet = '0; @(negedge clk);
    model[7][14] = 1'b1;
    check("R6 set", {63'h0, entTable[7*64+14]}, 64'h1);
    winWr(8'h1F, 32'hCAFE_0001);
    model[7][63:32] = 32'hCAFE_0001;
    check("R6 hi keeps", entTable[7*64 +: 64], model[7]);
    winWr(8'h1E, model[7][31:0] | 32'h4000);
    model[7][14] = 1'b0;
    check("R6 lo clears", entTable[7*64 +: 64], model[7]);
    access(1, 8'h00, 32'h20);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 8'h10; busWdata = 32'h0000_4042;
    remoteSet[8] = 1'b1;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0; remoteSet = '0;
    @(negedge clk);
    model[8][31:0] = 32'h0000_0042;
    check("R6 write wins", entTable[8*64 +: 64], model[8]);

    // R5: out-of-range indices
    winWr(8'h40, 32'h0);
    check("R5 no pulse", {63'h0, tblWr}, 64'h0);
    winWr(8'h05, 32'h0);
    check("R5 no pulse low", {63'h0, tblWr}, 64'h0);
    winWr(8'hFF, 32'h0);
    tableCheck("R5 table");

    // R2 R3 R4 R5: full index sweep
    for (int i = 0; i < 256; i++) begin
      winRd(8'(i), v);
      check("R5 sweep", {32'h0, v}, {32'h0, expRd(i)});
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule